// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is the device side of a single-wire, open-drain bus for a device that holds a fixed identity. It measures how long the shared line stays low. A long low period counts as a bus reset. After the master lets the line go, the block answers with a presence pulse. It then lets one 8-bit command pass without acting on it. After that it puts out a 64-bit identity, one bit in each read slot the master opens.

The block takes a one-microsecond tick, the bus level already brought into its clock domain, and drives a single pull-low output for an open-drain pad. The identity is an 8-bit family value followed by a 48-bit serial number, both given as parameters. The last byte is a CRC over those 56 bits, and the block works it out during elaboration. When all 64 bits have been sent, the block leaves the line alone until the next reset.

Top module: `sw_id_responder`

## Requirements
- R1: A low period of at least RESET_US (480) microseconds is taken as a reset in any state. Within one cycle the block releases the line and waits for the master to let it rise. A sequence that was cut short starts again from the beginning.
- R2: A presence pulse is never sent without a preceding reset. This holds after power-up, and it holds after a low period shorter than RESET_US. In those cases read slots see the line high.
- R3: When the master releases the line after a reset, the block stays released for PD_WAIT_US (30) microseconds. It then pulls the line low for PD_LOW_US (120) microseconds and releases it.
- R4: Identity bit i goes out in the i-th read slot. Bits 0 to 7 hold the family value 01h and bits 8 to 55 hold the serial number, each field least significant bit first. Bits 56 to 63 hold a CRC of bits 0 to 55 with polynomial x^8+x^5+x^4+1. The CRC register starts at zero and takes the bits in transmit order.
- R5: In a read slot, a 0 bit is sent by pulling the line low from the falling edge for HOLD_US (30) microseconds. A 1 bit is sent by leaving the line released.
- R6: After the presence pulse, the next 8 slots are write slots, each sampled SAMPLE_US (30) microseconds after its falling edge. The block never pulls the line during them.
- R7: After the 64th identity bit, the block releases the line and ignores all slots until a reset.
- R8: A reset in the middle of the identity stream means the next transaction sends the identity again from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_in | input | 1 | Synchronized bus level (1 = high) |
| pull_low | output | 1 | 1 drives the open-drain line low |

## Verification
The bench tries a 400 µs low period and read slots right after power-up. A design that treats any long low as a reset, or starts up ready to answer, would pull the line in those slots or send a presence pulse. It checks the line at points inside and outside the presence window. An off-by-one wait or pulse length would show high where low is expected, or the other way round. It writes random command bytes and compares all 64 read bits with an identity built from a stage-by-stage CRC model. This catches a reversed bit order, a miscounted command skip, and a wrong polynomial tap. It also cuts a stream short with a reset and then reads slots after the last bit. A stale bit index would resume mid-stream, and a missing stop would keep driving past bit 63.

// File: rtl/sw_id_pkg.sv
package sw_id_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLOW,
    ST_PDWAIT,
    ST_PDDRV,
    ST_CMD,
    ST_SEND,
    ST_DONE
  } sw_state_e;

  function automatic int int_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One serial step of the reflected x^8+x^5+x^4+1 checksum.
  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
  endfunction

  function automatic logic [7:0] crc_of56(input logic [55:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++) c = crc_step(c, d[i]);
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
    return {crc_of56({ser, fam}), ser, fam};
  endfunction

endpackage

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
  parameter int RESET_US = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bus_in,
  output logic reset_hit
);
  localparam int LW = $clog2(RESET_US + 1);

  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else if (bus_in) low_q <= '0;
    else if (us_tick && low_q != LW'(RESET_US)) low_q <= low_q + LW'(1);
  end

  // Single pulse when the low period reaches the threshold; counter saturates.
  assign reset_hit = !bus_in && us_tick && (low_q == LW'(RESET_US - 1));
endmodule

// File: rtl/sw_edge_det.sv
module sw_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic fall,
  output logic rise
);
  logic bus_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_d <= 1'b1;
    else bus_d <= bus_in;
  end

  assign fall = bus_d & ~bus_in;
  assign rise = ~bus_d & bus_in;
endmodule

// File: rtl/sw_id_rom.sv
module sw_id_rom #(
  parameter logic [7:0]  FAMILY = 8'h01,
  parameter logic [47:0] SERIAL = 48'h0000_1234_5678,
  parameter int          IW     = 6
) (
  input  logic [IW-1:0] idx,
  output logic          id_bit
);
  localparam logic [63:0] ID = sw_id_pkg::make_id(FAMILY, SERIAL);

  assign id_bit = ID[idx];
endmodule

// File: rtl/sw_id_responder.sv
module sw_id_responder
  import sw_id_pkg::*;
#(
  parameter logic [7:0]  FAMILY     = 8'h01,
  parameter logic [47:0] SERIAL     = 48'h0000_1234_5678,
  parameter int          RESET_US   = 480,
  parameter int          PD_WAIT_US = 30,
  parameter int          PD_LOW_US  = 120,
  parameter int          SAMPLE_US  = 30,
  parameter int          HOLD_US    = 30,
  parameter int          CMD_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bus_in,
  output logic pull_low
);
  localparam int ID_BITS = 64;
  localparam int IW      = $clog2(ID_BITS);
  localparam int TMAX    = int_max(int_max(PD_WAIT_US, PD_LOW_US), int_max(SAMPLE_US, HOLD_US));
  localparam int TW      = $clog2(TMAX + 1);

  sw_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [IW-1:0] idx_q;
  logic          slot_on_q;
  logic          pull_q;

  logic reset_hit, slot_fall, bus_rise, id_bit, slot_end;

  sw_low_timer #(.RESET_US(RESET_US)) u_low (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in), .reset_hit(reset_hit)
  );

  sw_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .fall(slot_fall), .rise(bus_rise)
  );

  sw_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL), .IW(IW)) u_rom (
    .idx(idx_q), .id_bit(id_bit)
  );

  // End of the timed part of a write or read slot.
  always_comb begin
    slot_end = 1'b0;
    if (slot_on_q && us_tick && !slot_fall) begin
      if (state_q == ST_CMD)  slot_end = (tcnt_q == TW'(SAMPLE_US - 1));
      if (state_q == ST_SEND) slot_end = (tcnt_q == TW'(HOLD_US - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      idx_q     <= '0;
      slot_on_q <= 1'b0;
      pull_q    <= 1'b0;
    end else if (reset_hit) begin
      state_q   <= ST_RSTLOW;
      tcnt_q    <= '0;
      idx_q     <= '0;
      slot_on_q <= 1'b0;
      pull_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RSTLOW: if (bus_rise) begin
          state_q <= ST_PDWAIT;
          tcnt_q  <= '0;
        end
        ST_PDWAIT: if (us_tick) begin
          if (tcnt_q == TW'(PD_WAIT_US - 1)) begin
            state_q <= ST_PDDRV;
            tcnt_q  <= '0;
            pull_q  <= 1'b1;
          end else tcnt_q <= tcnt_q + TW'(1);
        end
        ST_PDDRV: if (us_tick) begin
          if (tcnt_q == TW'(PD_LOW_US - 1)) begin
            state_q <= ST_CMD;
            tcnt_q  <= '0;
            idx_q   <= '0;
            pull_q  <= 1'b0;
          end else tcnt_q <= tcnt_q + TW'(1);
        end
        ST_CMD: begin
          if (slot_fall) begin
            slot_on_q <= 1'b1;
            tcnt_q    <= '0;
          end else if (slot_end) begin
            slot_on_q <= 1'b0;
            if (idx_q == IW'(CMD_BITS - 1)) begin
              state_q <= ST_SEND;
              idx_q   <= '0;
            end else idx_q <= idx_q + IW'(1);
          end else if (slot_on_q && us_tick) tcnt_q <= tcnt_q + TW'(1);
        end
        ST_SEND: begin
          if (slot_fall) begin
            slot_on_q <= 1'b1;
            tcnt_q    <= '0;
            pull_q    <= ~id_bit;
          end else if (slot_end) begin
            slot_on_q <= 1'b0;
            pull_q    <= 1'b0;
            if (idx_q == IW'(ID_BITS - 1)) state_q <= ST_DONE;
            else idx_q <= idx_q + IW'(1);
          end else if (slot_on_q && us_tick) tcnt_q <= tcnt_q + TW'(1);
        end
        default: ;
      endcase
    end
  end

  assign pull_low = pull_q;
endmodule

// File: rtl/sw_id_responder_sva.sv
module sw_id_responder_sva
  import sw_id_pkg::*;
#(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pull_low,
  input logic          reset_hit,
  input logic          slot_fall,
  input logic          slot_end,
  input sw_state_e     state,
  input logic [IW-1:0] idx
);
  AST_RESET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> (!pull_low && state == ST_RSTLOW)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pull_low); // R2
  AST_PRESENCE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_PDDRV) |-> $past(state == ST_PDWAIT)); // R2
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDWAIT) |-> !pull_low); // R3
  AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && slot_end && !reset_hit && idx != '1) |=> (idx == $past(idx) + 1'b1)); // R4
  AST_PULL_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low) |-> ($past(slot_fall) || state == ST_PDDRV)); // R5
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMD) |-> !pull_low); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> !pull_low); // R7
endmodule

bind sw_id_responder sw_id_responder_sva #(.IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .pull_low(pull_low), .reset_hit(reset_hit),
  .slot_fall(slot_fall), .slot_end(slot_end), .state(state_q), .idx(idx_q)
);

// File: tb/sw_id_responder_bench.sv
module sw_id_responder_bench;
  localparam logic [47:0] SER = 48'h5AC3_19E7_0B42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_q;
  logic master_low = 1'b0;
  logic pull_low;
  logic bus_in;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic [63:0] exp_id;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else tick_q <= ~tick_q;
  end

  assign bus_in = ~(master_low | pull_low);

  sw_id_responder #(.SERIAL(SER)) u_sw_id_responder (
    .clk(clk), .rst_n(rst_n), .us_tick(tick_q), .bus_in(bus_in), .pull_low(pull_low)
  );

  // Stage-by-stage model of the x^8+x^5+x^4+1 shift-register CRC.
  function automatic logic [7:0] stage_crc(input logic [63:0] bits, input int n);
    logic [7:0] s, ns;
    logic fb;
    s = 8'h00;
    for (int i = 0; i < n; i++) begin
      fb = s[0] ^ bits[i];
      ns[7] = fb;       ns[6] = s[7];      ns[5] = s[6];      ns[4] = s[5];
      ns[3] = s[4] ^ fb; ns[2] = s[3] ^ fb; ns[1] = s[2];      ns[0] = s[1];
      s = ns;
    end
    return s;
  endfunction

  function automatic logic [63:0] expect_id();
    logic [63:0] v;
    v[7:0]  = 8'h01;
    v[55:8] = SER;
    v[63:56] = stage_crc({8'h00, v[55:0]}, 56);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic bus_low(input int n);
    master_low = 1'b1;
    wait_us(n);
    master_low = 1'b0;
  endtask

  // Observes the line after the master releases; pd says whether presence is due.
  task automatic watch_presence(input bit pd, input string req);
    wait_us(15);
    chk(bus_in == 1'b1, req, bus_in, 1);
    wait_us(30);
    chk(bus_in == !pd, req, bus_in, !pd);
    wait_us(95);
    chk(bus_in == !pd, req, bus_in, !pd);
    wait_us(30);
    chk(bus_in == 1'b1, req, bus_in, 1);
  endtask

  task automatic write_bit(input bit b);
    if (b) begin
      bus_low(5);
      wait_us(25);
      chk(bus_in == 1'b1, "R6 write-one slot", bus_in, 1);
      wait_us(45);
    end else begin
      bus_low(65);
      chk(pull_low == 1'b0, "R6 write-zero slot", pull_low, 0);
      wait_us(10);
    end
  endtask

  task automatic read_bit(output logic v);
    bus_low(2);
    wait_us(13);
    v = bus_in;
    wait_us(60);
  endtask

  task automatic start_txn(input int rlen);
    logic [7:0] cmd;
    bus_low(rlen);
    watch_presence(1'b1, "R3 presence window");
    cmd = 8'($urandom);
    for (int i = 0; i < 8; i++) write_bit(cmd[i]);
  endtask

  task automatic read_ids(input int n, input string req);
    logic v;
    for (int i = 0; i < n; i++) begin
      read_bit(v);
      chk(v == exp_id[i], req, v, exp_id[i]);
    end
  endtask

  initial begin
    logic v;
    void'($urandom(32'd4242));
    exp_id = expect_id();
    chk(stage_crc(exp_id, 64) == 8'h00, "R4 checksum closes", stage_crc(exp_id, 64), 0);
    repeat (5) @(negedge clk);
    chk(pull_low == 1'b0, "R2 reset state", pull_low, 0);
    rst_n = 1'b1;
    wait_us(5);
    // R2: slots at power-up, then a low period too short to be a reset
    for (int i = 0; i < 3; i++) begin
      read_bit(v);
      chk(v == 1'b1, "R2 no reset yet", v, 1);
    end
    bus_low(400);
    watch_presence(1'b0, "R2 short low");
    // Full transactions with random reset lengths and command bytes
    for (int t = 0; t < 3; t++) begin
      start_txn(500 + int'($urandom % 300));
      read_ids(64, "R4 R5 identity bit");
      for (int i = 0; i < 3; i++) begin
        read_bit(v);
        chk(v == 1'b1, "R7 after last bit", v, 1);
      end
      wait_us(20);
    end
    // R8: reset cut into the stream, then a full restart (R1 from mid-stream)
    start_txn(490);
    read_ids(11, "R4 partial");
    bus_low(520);
    watch_presence(1'b1, "R1 reset mid-stream");
    for (int i = 0; i < 8; i++) write_bit(1'b1);
    read_ids(64, "R8 restart from bit 0");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule